// File: doc/BRIEF.md
# Cycle-Skipping ON/OFF Switch Controller

This block drives the gate of a power switch in a converter that regulates by whole-cycle skipping, with no pulse-width error loop. A cycle runs from one `cyc_start` clock to the next. On the `cyc_start` clock the block takes one sample of the synchronized feedback-enable flag. If the flag is high and nothing holds the switch off, the switch conducts during that cycle. If not, the cycle is skipped in full.

A conducting pulse ends at the first of these events: the maximum-duty window closes, the current-limit comparator trips once the blanking interval has passed, a protection hold appears, or the feedback overvoltage detector fires. The overvoltage detector watches for the shutdown flag in two enabled cycles in a row. When it fires, it stops the pulse and sends a one-clock request to the external fault timer to start the auto-restart off period. That timer then holds `restart_inhibit` for as long as the off period lasts.

Top module: `onoff_switch_ctrl`

## Requirements
- R1: On a clock where `cyc_start` is high, the gate goes high at the next edge when `fb_en` and `duty_win` are both 1 and no hold is active. When `fb_en` is 0 on that clock, the gate stays low for the whole cycle.
- R2: A change of `fb_en` on any clock other than a `cyc_start` clock has no effect on the gate.
- R3: `ilim_trip` is ignored for the first BLANK_CLKS clocks after the edge that raised the gate. After that, a high `ilim_trip` drives the gate low at the next edge, and the gate stays low until the next `cyc_start`.
- R4: While `duty_win` is 0, the gate is low from the next edge on.
- R5: `supply_low` (1 = undervoltage) blocks turn-on and ends a pulse at the next edge. After it clears, switching resumes only at a later `cyc_start`.
- R6: `over_temp` (1 = too hot) blocks turn-on and ends a pulse at the next edge. After it clears, switching resumes only at a later `cyc_start`.
- R7: While `restart_inhibit` is 1, every cycle is skipped, whatever `fb_en` does.
- R8: The detector fires when `fb_ovp` is high on some clock of an enabled cycle and again on some clock of the next cycle, which is also enabled. A `cyc_start` clock counts toward the cycle it ends. When it fires, the gate goes low at the next edge, and `restart_req` pulses high for exactly one clock at that same edge.
- R9: The two-cycle count starts over after a skipped cycle, after an enabled cycle in which `fb_ovp` never went high, and after a trip.
- R10: While `rst` is high, `gate` and `restart_req` are 0 at every edge, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock pulse that opens a switching cycle |
| duty_win | input | 1 | Maximum-duty window; conduction is allowed only while it is high |
| fb_en | input | 1 | Synchronized feedback enable; sampled on `cyc_start` only |
| ilim_trip | input | 1 | Current-limit comparator output |
| fb_ovp | input | 1 | Feedback overvoltage-shutdown flag |
| supply_low | input | 1 | Supply undervoltage, with hysteresis resolved upstream |
| over_temp | input | 1 | Over-temperature flag, with hysteresis resolved upstream |
| restart_inhibit | input | 1 | Auto-restart off period in progress |
| gate | output | 1 | Registered switch gate command |
| restart_req | output | 1 | One-clock request to start the auto-restart off period |

## Verification
The hardest state to reach from the ports is the overvoltage trip. It needs a hit in one enabled cycle, then a second hit inside the following enabled cycle, with no skipped or clean cycle in between. The stimulus builds this up in stages. First a single hit shows no trip. Next a skipped cycle between two hits shows the count restarting. Then two adjacent hit cycles produce the trip and the single request pulse. Finally a clean enabled cycle placed between two hits shows the count restarting again. Blanking is covered by holding `ilim_trip` high from the turn-on edge onward, so the exact edge at which the pulse ends can be counted.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  // Conditions that keep the switch off for as long as they last
  typedef struct packed {
    logic supply_low;
    logic over_temp;
    logic inhibit;
  } hold_t;

  function automatic logic any_hold(input hold_t h);
    return h.supply_low | h.over_temp | h.inhibit;
  endfunction

  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/ssc_cycle_sampler.sv
module ssc_cycle_sampler
  import ssc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cyc_start,
  input  logic  duty_win,
  input  logic  fb_en,
  input  hold_t hold,
  input  logic  fire,
  output logic  turn_on,
  output logic  cyc_en
);

  // Decision taken once per cycle, on the start clock only
  assign turn_on = cyc_start & fb_en & duty_win & ~any_hold(hold) & ~fire;

  always_ff @(posedge clk) begin
    if (rst)            cyc_en <= 1'b0;
    else if (cyc_start) cyc_en <= turn_on;
    else if (fire)      cyc_en <= 1'b0;
  end

  // R2
  en_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc_start |=> !$rose(cyc_en));

endmodule

// File: rtl/ssc_blank_timer.sv
module ssc_blank_timer #(
  parameter int BLANK_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic turn_on,
  input  logic gate_on,
  output logic blank_done
);
  import ssc_pkg::*;

  localparam int CW = cnt_width(BLANK_CLKS);

  generate
    if (BLANK_CLKS == 0) begin : g_none
      assign blank_done = 1'b1;
    end else begin : g_cnt
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst)                                  cnt <= '0;
        else if (turn_on)                         cnt <= '0;
        else if (gate_on && cnt != CW'(BLANK_CLKS)) cnt <= cnt + 1'b1;
      end

      assign blank_done = (cnt == CW'(BLANK_CLKS));

      // R3
      blank_restart_chk: assert property (@(posedge clk) disable iff (rst)
        turn_on |=> !blank_done);
    end
  endgenerate

endmodule

// File: rtl/ssc_ovp_watch.sv
module ssc_ovp_watch (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic cyc_en,
  input  logic fb_ovp,
  output logic fire,
  output logic restart_req
);

  logic seen_q;      // current enabled cycle has seen the flag
  logic prev_hit_q;  // previous cycle was enabled and saw the flag
  logic hit_now;

  assign hit_now = cyc_en & (seen_q | fb_ovp);
  assign fire    = prev_hit_q & cyc_en & fb_ovp;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q      <= 1'b0;
      prev_hit_q  <= 1'b0;
      restart_req <= 1'b0;
    end else begin
      restart_req <= fire;
      if (fire) begin
        seen_q     <= 1'b0;
        prev_hit_q <= 1'b0;
      end else if (cyc_start) begin
        seen_q     <= 1'b0;
        prev_hit_q <= hit_now;
      end else begin
        seen_q     <= hit_now;
      end
    end
  end

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    restart_req |=> !restart_req);

endmodule

// File: rtl/onoff_switch_ctrl.sv
module onoff_switch_ctrl #(
  parameter int BLANK_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic duty_win,
  input  logic fb_en,
  input  logic ilim_trip,
  input  logic fb_ovp,
  input  logic supply_low,
  input  logic over_temp,
  input  logic restart_inhibit,
  output logic gate,
  output logic restart_req
);
  import ssc_pkg::*;

  hold_t hold;
  logic  turn_on, cyc_en, blank_done, ovp_fire, stop, gate_d;

  assign hold = {supply_low, over_temp, restart_inhibit};

  ssc_cycle_sampler u_smp (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .duty_win(duty_win),
    .fb_en(fb_en), .hold(hold), .fire(ovp_fire),
    .turn_on(turn_on), .cyc_en(cyc_en)
  );

  ssc_blank_timer #(.BLANK_CLKS(BLANK_CLKS)) u_blk (
    .clk(clk), .rst(rst), .turn_on(turn_on), .gate_on(gate),
    .blank_done(blank_done)
  );

  ssc_ovp_watch u_ovp (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_en(cyc_en),
    .fb_ovp(fb_ovp), .fire(ovp_fire), .restart_req(restart_req)
  );

  assign stop = ~duty_win | (ilim_trip & blank_done) | any_hold(hold) | ovp_fire;

  always_comb begin
    if (cyc_start) gate_d = turn_on;
    else           gate_d = gate & ~stop;
  end

  always_ff @(posedge clk) begin
    if (rst) gate <= 1'b0;
    else     gate <= gate_d;
  end

  // R1
  gate_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate) |-> $past(cyc_start & fb_en));

  // R5 R6 R7
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    gate |-> !$past(supply_low | over_temp | restart_inhibit));

  // R4
  duty_end_chk: assert property (@(posedge clk) disable iff (rst)
    !duty_win |=> !gate);

  // R3
  ilim_end_chk: assert property (@(posedge clk) disable iff (rst)
    (gate && ilim_trip && blank_done && !cyc_start) |=> !gate);

  // R8
  req_gate_chk: assert property (@(posedge clk) disable iff (rst)
    restart_req |-> !gate);

endmodule

// File: tb/onoff_switch_ctrl_tb_top.sv
`timescale 1ns/1ps
module onoff_switch_ctrl_tb_top;

  localparam int BLK = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 0, dw = 0, fe = 0, il = 0, ov = 0, uv = 0, ot = 0, inh = 0;
  logic gate, restart_req;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    int    due;
    logic  g;
    logic  r;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  onoff_switch_ctrl #(.BLANK_CLKS(BLK)) dut_i (
    .clk(clk), .rst(rst), .cyc_start(cs), .duty_win(dw), .fb_en(fe),
    .ilim_trip(il), .fb_ovp(ov), .supply_low(uv), .over_temp(ot),
    .restart_inhibit(inh), .gate(gate), .restart_req(restart_req)
  );

  // Driver: inputs already set; push what the outputs must show after the next edge
  task automatic step(input logic eg, input logic er, input string tag);
    exp_t e;
    e.due = cyc + 1; e.g = eg; e.r = er; e.tag = tag;
    q.push_back(e);
    @(posedge clk); #1;
  endtask

  // Monitor: compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due == cyc) begin
        checks++;
        if (gate !== q[0].g || restart_req !== q[0].r) begin
          fails++;
          $display("FAIL %s: gate/req actual %b/%b expected %b/%b (cycle %0d)",
                   q[0].tag, gate, restart_req, q[0].g, q[0].r, cyc);
        end
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    // R10: reset dominates active inputs
    cs = 1; dw = 1; fe = 1; il = 0; ov = 1;
    step(0, 0, "R10 reset");
    step(0, 0, "R10 reset");
    step(0, 0, "R10 reset");
    rst = 0; cs = 0; dw = 0; fe = 0; ov = 0;
    step(0, 0, "R10 idle after reset");

    // R1 enabled cycle, R2 late fb change, R4 duty end
    cs = 1; dw = 1; fe = 1; step(1, 0, "R1 enabled cycle");
    cs = 0; fe = 0;         step(1, 0, "R2 late fb drop ignored");
    step(1, 0, "R2 late fb drop ignored");
    dw = 0;                 step(0, 0, "R4 duty window end");
    step(0, 0, "R4 stays off");

    // R1 skipped cycle, R2 late fb rise
    cs = 1; dw = 1; fe = 0; step(0, 0, "R1 skipped cycle");
    cs = 0; fe = 1;         step(0, 0, "R2 late fb rise ignored");
    step(0, 0, "R2 late fb rise ignored");
    dw = 0; fe = 0;         step(0, 0, "R4 idle");

    // R3 blanking
    cs = 1; dw = 1; fe = 1; step(1, 0, "R1 enabled cycle");
    cs = 0; il = 1;
    for (int i = 0; i < BLK; i++) step(1, 0, "R3 ilim blanked");
    step(0, 0, "R3 ilim ends pulse");
    il = 0;                 step(0, 0, "R3 off for rest of cycle");
    dw = 0;                 step(0, 0, "R3 idle");
    cs = 1; dw = 1; il = 1; step(1, 0, "R3 turn-on ignores ilim");
    cs = 0;
    for (int i = 0; i < BLK; i++) step(1, 0, "R3 blanking restarts");
    step(0, 0, "R3 ilim ends second pulse");
    il = 0; dw = 0;         step(0, 0, "R3 idle");

    // R5 undervoltage
    uv = 1; cs = 1; dw = 1; fe = 1; step(0, 0, "R5 undervoltage blocks");
    cs = 0;                 step(0, 0, "R5 blocked");
    uv = 0;                 step(0, 0, "R5 waits for next start");
    cs = 1;                 step(1, 0, "R5 recovered");
    cs = 0; uv = 1;         step(0, 0, "R5 ends pulse");
    uv = 0; dw = 0;         step(0, 0, "R5 idle");

    // R6 over-temperature
    ot = 1; cs = 1; dw = 1; step(0, 0, "R6 over-temp blocks");
    cs = 0;                 step(0, 0, "R6 blocked");
    ot = 0;                 step(0, 0, "R6 waits for next start");
    cs = 1;                 step(1, 0, "R6 recovered");
    cs = 0; ot = 1;         step(0, 0, "R6 ends pulse");
    ot = 0; dw = 0;         step(0, 0, "R6 idle");

    // R7 restart inhibit
    inh = 1; cs = 1; dw = 1; step(0, 0, "R7 inhibit skips");
    cs = 0;                 step(0, 0, "R7 inhibit skips");
    dw = 0;                 step(0, 0, "R7 idle");
    cs = 1; dw = 1;         step(0, 0, "R7 inhibit skips again");
    cs = 0; inh = 0; dw = 0; step(0, 0, "R7 idle");
    cs = 1; dw = 1;         step(1, 0, "R7 released");
    cs = 0; dw = 0;         step(0, 0, "R7 idle");

    // R9: hit, skipped cycle, hit -> no trip
    cs = 1; dw = 1; fe = 1; step(1, 0, "R8 cycle A");
    cs = 0; ov = 1;         step(1, 0, "R8 single hit no trip");
    ov = 0; dw = 0;         step(0, 0, "R8 idle");
    cs = 1; dw = 1; fe = 0; step(0, 0, "R9 skipped cycle");
    cs = 0; ov = 1;         step(0, 0, "R9 hit in skipped cycle");
    ov = 0; dw = 0;         step(0, 0, "R9 idle");
    cs = 1; dw = 1; fe = 1; step(1, 0, "R9 cycle C");
    cs = 0; ov = 1;         step(1, 0, "R9 count restarted after skip");
    ov = 0; dw = 0;         step(0, 0, "R9 idle");
    // R8: hit in next enabled cycle -> trip
    cs = 1; dw = 1;         step(1, 0, "R8 cycle D");
    cs = 0;                 step(1, 0, "R8 cycle D");
    ov = 1;                 step(0, 1, "R8 trip");
    ov = 0;                 step(0, 0, "R8 single request pulse");
    dw = 0;                 step(0, 0, "R8 idle");
    // R9: trip clears count; then clean cycle between hits
    cs = 1; dw = 1;         step(1, 0, "R9 cycle E");
    cs = 0; ov = 1;         step(1, 0, "R9 count restarted after trip");
    ov = 0; dw = 0;         step(0, 0, "R9 idle");
    cs = 1; dw = 1;         step(1, 0, "R9 clean cycle F");
    cs = 0;                 step(1, 0, "R9 clean cycle F");
    dw = 0;                 step(0, 0, "R9 idle");
    cs = 1; dw = 1;         step(1, 0, "R9 cycle G");
    cs = 0; ov = 1;         step(1, 0, "R9 count restarted after clean cycle");
    ov = 0; dw = 0;         step(0, 0, "R9 idle");

    @(posedge clk); @(negedge clk); #1;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule